// File: doc/BRIEF.md
# Half-Bridge Dead-Time Gate Controller

This block sits between a PWM source and the gate drivers of one half-bridge leg. It takes two logic commands and produces registered gate-enable outputs for the high-side and low-side switches. The high-side command is active high. The low-side command is active low. When both commands ask for conduction at once, both gates are kept off. Any off-to-on transfer between the two switches waits a minimum number of clock cycles with both gates off. Commanded gaps that already exceed that minimum pass through with no added delay.

External comparators report three conditions as synchronous flags: an undervoltage on the logic/low-side supply, an undervoltage on the floating high-side supply, and a negative excursion of the switch node. The logic-supply flag turns both gates off. The floating-supply flag turns off only the high side. A switch-node flag that is held long enough blanks the high side for a fixed period. After either undervoltage lockout, a gate comes back only on a freshly issued command.

All times are counted in clock cycles. The defaults assume a 100 MHz clock: a 53-cycle dead time (530 ns), a transient that must last longer than 5 cycles (50 ns), and a 450-cycle blanking period (4.5 µs).

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: `gate_hi` is high only if `hi_cmd` was high at the previous rising clock edge. When `hi_cmd` drops, `gate_hi` is low one cycle later.
- R2: The low-side command `lo_cmd_n` is active low (0 = conduct). `gate_lo` is high only if `lo_cmd_n` was 0 at the previous edge. When `lo_cmd_n` rises, `gate_lo` is low one cycle later.
- R3: `gate_hi` and `gate_lo` are never high together. In the cycle after an edge that samples `hi_cmd`=1 with `lo_cmd_n`=0, both gates are low.
- R4: Either gate rises only after both gates have been low for at least `DEAD_CYC` consecutive cycles. This holds for both transition directions. With a zero commanded gap, the incoming gate rises exactly `DEAD_CYC` cycles after the outgoing gate fell.
- R5: When the commanded gap is already `DEAD_CYC` cycles or longer, the gate rises one cycle after its command, the same latency as a turn-off.
- R6: While `uv_main` is 1, both gates are low from the next cycle on. This includes the period right after reset, before the supply is first valid.
- R7: While `uv_float` is 1, `gate_hi` is low from the next cycle on. `gate_lo` keeps following its command.
- R8: `neg_tr` counts only when it is sampled high at more than `QUAL_CYC` consecutive edges. On the qualifying edge, `gate_hi` is forced low for `BLANK_CYC` edges. Shorter pulses have no effect.
- R9: If a side's command is active while a lockout that covers that side is asserted (`uv_main` for both sides, `uv_float` for the high side), that side stays off after the flag clears. It stays off until its command has been seen inactive and then active again.
- R10: Reset (`rst_n` low, asynchronous) drives both gates low immediately. The first turn-on after release happens no earlier than `DEAD_CYC` cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 1 | High-side command, 1 = conduct |
| lo_cmd_n | input | 1 | Low-side command, 0 = conduct |
| uv_main | input | 1 | Logic/low-side supply undervoltage flag, 1 = fault |
| uv_float | input | 1 | Floating high-side supply undervoltage flag, 1 = fault |
| neg_tr | input | 1 | Negative switch-node transient flag, 1 = excursion present |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
Every gate result is registered, so a turn-off, a lockout or a conflict shows at the ports one cycle after the edge that samples the cause. A zero-gap transfer completes `DEAD_CYC` cycles after the outgoing gate fell. A qualifying transient takes effect on the edge after `QUAL_CYC` consecutive high samples, and the high side returns `BLANK_CYC` cycles later. The bench changes inputs and samples outputs only on falling edges. Each directed check is placed by counting edges from its stimulus. A behavioural model steps on each rising edge and is compared on every falling edge.

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
  parameter int DEAD_CYC  = 53,
  parameter int QUAL_CYC  = 5,
  parameter int BLANK_CYC = 450
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd,
  input  logic lo_cmd_n,
  input  logic uv_main,
  input  logic uv_float,
  input  logic neg_tr,
  output logic gate_hi,
  output logic gate_lo
);

  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [DW-1:0] IDLE_TOP  = DW'(DEAD_CYC - 1);
  localparam logic [QW-1:0] QUAL_TOP  = QW'(QUAL_CYC);
  localparam logic [BW-1:0] BLANK_TOP = BW'(BLANK_CYC - 1);

  logic [DW-1:0] idle_q;
  logic [QW-1:0] tr_run_q;
  logic [BW-1:0] blank_q;
  logic          hold_h_q, hold_l_q;

  logic lo_req, conflict, fire, blanking, lock_h, ready;
  logic en_h, en_l, hi_nx, lo_nx;

  assign lo_req   = ~lo_cmd_n;
  assign conflict = hi_cmd & lo_req;
  assign fire     = neg_tr & (tr_run_q == QUAL_TOP);
  assign blanking = fire | (blank_q != '0);
  assign lock_h   = uv_main | uv_float | blanking;
  assign ready    = (idle_q == IDLE_TOP);

  assign en_h = hi_cmd & ~conflict & ~lock_h  & ~hold_h_q;
  assign en_l = lo_req & ~conflict & ~uv_main & ~hold_l_q;

  assign hi_nx = en_h & (gate_hi | (~gate_lo & ready));
  assign lo_nx = en_l & (gate_lo | (~gate_hi & ready));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= hi_nx;
      gate_lo <= lo_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idle_q <= '0;
    else if (gate_hi | gate_lo)
      idle_q <= '0;
    else if (!ready)
      idle_q <= idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_h_q <= 1'b0;
      hold_l_q <= 1'b0;
    end else begin
      hold_h_q <= hi_cmd & (hold_h_q | uv_main | uv_float);
      hold_l_q <= lo_req & (hold_l_q | uv_main);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tr_run_q <= '0;
    else if (!neg_tr)
      tr_run_q <= '0;
    else if (tr_run_q != QUAL_TOP)
      tr_run_q <= tr_run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      blank_q <= '0;
    else if (fire)
      blank_q <= BLANK_TOP;
    else if (blank_q != '0)
      blank_q <= blank_q - 1'b1;
  end

endmodule

// File: rtl/hb_deadtime_ctrl_chk.sv
module hb_deadtime_ctrl_chk #(
  parameter int DEAD_CYC  = 53,
  parameter int QUAL_CYC  = 5,
  parameter int BLANK_CYC = 450
) (
  input logic clk,
  input logic rst_n,
  input logic hi_cmd,
  input logic lo_cmd_n,
  input logic uv_main,
  input logic uv_float,
  input logic neg_tr,
  input logic gate_hi,
  input logic gate_lo
);

  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [DW-1:0] off_run;
  logic [QW-1:0] tr_seen;
  logic [BW-1:0] hush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      off_run <= '0;
    else if (gate_hi || gate_lo)
      off_run <= '0;
    else if (off_run != DW'(DEAD_CYC))
      off_run <= off_run + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tr_seen <= '0;
      hush    <= '0;
    end else begin
      if (!neg_tr) tr_seen <= '0;
      else if (tr_seen != QW'(QUAL_CYC)) tr_seen <= tr_seen + 1'b1;
      if (neg_tr && tr_seen == QW'(QUAL_CYC)) hush <= BW'(BLANK_CYC);
      else if (hush != '0) hush <= hush - 1'b1;
    end
  end

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R3
  conflict_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cmd && !lo_cmd_n) |=> (!gate_hi && !gate_lo));

  // R1
  hi_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_cmd |=> !gate_hi);

  // R2
  lo_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cmd_n |=> !gate_lo);

  // R4
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) || $rose(gate_lo)) |-> (off_run >= DW'(DEAD_CYC)));

  // R6
  main_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_main |=> (!gate_hi && !gate_lo));

  // R7
  float_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_float |=> !gate_hi);

  // R8
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hush != '0) |-> !gate_hi);

endmodule

bind hb_deadtime_ctrl hb_deadtime_ctrl_chk #(
  .DEAD_CYC(DEAD_CYC), .QUAL_CYC(QUAL_CYC), .BLANK_CYC(BLANK_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd_n(lo_cmd_n),
  .uv_main(uv_main), .uv_float(uv_float), .neg_tr(neg_tr),
  .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/test_hb_deadtime_ctrl.sv
`timescale 1ns/1ps
module test_hb_deadtime_ctrl;
  localparam int DEAD  = 53;
  localparam int QUAL  = 5;
  localparam int BLANK = 450;

  logic clk = 1'b0;
  logic rst_n, hi_cmd, lo_cmd_n, uv_main, uv_float, neg_tr;
  logic gate_hi, gate_lo;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit live = 1'b0;
  string phase = "R10";

  always #2 clk = ~clk;

  hb_deadtime_ctrl #(.DEAD_CYC(DEAD), .QUAL_CYC(QUAL), .BLANK_CYC(BLANK)) i_hb_deadtime_ctrl (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd_n(lo_cmd_n),
    .uv_main(uv_main), .uv_float(uv_float), .neg_tr(neg_tr),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // behavioural reference, stepped on rising edges
  bit m_hi, m_lo, m_need_h, m_need_l;
  int m_gap, m_run, m_blank;

  always @(posedge clk) begin
    live <= rst_n;
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_need_h = 0; m_need_l = 0;
      m_gap = 0; m_run = 0; m_blank = 0;
    end else begin
      bit want_h, want_l, fire, forced, nh, nl;
      int elapsed;
      elapsed = (!m_hi && !m_lo) ? m_gap + 1 : 0;
      fire = neg_tr && (m_run >= QUAL);
      m_run = neg_tr ? m_run + 1 : 0;
      if (fire) m_blank = BLANK;
      forced = (m_blank > 0);
      if (m_blank > 0) m_blank = m_blank - 1;
      want_h = hi_cmd && lo_cmd_n && !uv_main && !uv_float && !forced && !m_need_h;
      want_l = !lo_cmd_n && !hi_cmd && !uv_main && !m_need_l;
      nh = want_h && (m_hi || (!m_lo && elapsed >= DEAD));
      nl = want_l && (m_lo || (!m_hi && elapsed >= DEAD));
      m_need_h = hi_cmd && (m_need_h || uv_main || uv_float);
      m_need_l = !lo_cmd_n && (m_need_l || uv_main);
      m_gap = (elapsed > 100000) ? 100000 : elapsed;
      m_hi = nh;
      m_lo = nl;
    end
  end

  always @(negedge clk) begin
    if (live && rst_n && !done) begin
      tests++;
      if (gate_hi !== m_hi || gate_lo !== m_lo) begin
        fails++;
        $display("FAIL %s model: gate_hi=%b gate_lo=%b expected %b %b at %0t",
                 phase, gate_hi, gate_lo, m_hi, m_lo, $time);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit eh, input bit el, input string tag);
    tests++;
    if (gate_hi !== eh || gate_lo !== el) begin
      fails++;
      $display("FAIL %s: gate_hi=%b gate_lo=%b expected %b %b", tag, gate_hi, gate_lo, eh, el);
    end
  endtask

  initial begin
    rst_n = 0; hi_cmd = 1; lo_cmd_n = 1; uv_main = 1; uv_float = 0; neg_tr = 0;
    step(3);
    chk(0, 0, "R10 reset state");
    rst_n = 1; phase = "R6";
    step(DEAD + 5);  chk(0, 0, "R6 supply not yet valid");
    uv_main = 0; phase = "R9";
    step(DEAD + 5);  chk(0, 0, "R9 stale high command after supply valid");
    hi_cmd = 0; step(2); hi_cmd = 1; step(1);
    chk(1, 0, "R5 long gap turns on next cycle");

    phase = "R4";
    hi_cmd = 0; lo_cmd_n = 0;
    step(1);         chk(0, 0, "R1 high drops one cycle after command");
    step(DEAD - 1);  chk(0, 0, "R4 hi-to-lo dead time held");
    step(1);         chk(0, 1, "R4 low on after dead time");
    lo_cmd_n = 1; hi_cmd = 1;
    step(DEAD);      chk(0, 0, "R4 lo-to-hi dead time held");
    step(1);         chk(1, 0, "R4 high on after dead time");

    phase = "R5";
    hi_cmd = 0;
    step(DEAD + 10); chk(0, 0, "R5 idle gap");
    lo_cmd_n = 0;
    step(1);         chk(0, 1, "R5 low on one cycle after command");
    lo_cmd_n = 1;
    step(1);         chk(0, 0, "R2 low off after inactive level");

    phase = "R3";
    lo_cmd_n = 0;
    step(DEAD + 2);  chk(0, 1, "R2 low on for active-low command");
    hi_cmd = 1;
    step(1);         chk(0, 0, "R3 conflict turns both off");
    step(DEAD + 5);  chk(0, 0, "R3 conflict held");
    hi_cmd = 0;
    step(1);         chk(0, 1, "R3 low resumes after conflict");

    phase = "R7";
    uv_float = 1;
    step(DEAD + 5);  chk(0, 1, "R7 low unaffected by floating flag");
    lo_cmd_n = 1; hi_cmd = 1;
    step(DEAD + 5);  chk(0, 0, "R7 high blocked by floating flag");
    uv_float = 0; phase = "R9";
    step(DEAD + 5);  chk(0, 0, "R9 high waits for fresh command");
    hi_cmd = 0; step(1); hi_cmd = 1;
    step(1);         chk(1, 0, "R9 fresh high command accepted");

    phase = "R6";
    uv_main = 1;
    step(1);         chk(0, 0, "R6 high off on supply flag");
    hi_cmd = 0; lo_cmd_n = 0;
    step(DEAD + 5);  chk(0, 0, "R6 low blocked on supply flag");
    uv_main = 0; phase = "R9";
    step(DEAD + 5);  chk(0, 0, "R9 low waits for fresh command");
    lo_cmd_n = 1; step(1); lo_cmd_n = 0;
    step(1);         chk(0, 1, "R9 fresh low command accepted");

    phase = "R8";
    lo_cmd_n = 1; hi_cmd = 1;
    step(DEAD + 5);  chk(1, 0, "R8 high on before transient");
    neg_tr = 1; step(QUAL); neg_tr = 0;
    step(1);         chk(1, 0, "R8 short pulse ignored");
    neg_tr = 1;
    step(QUAL);      chk(1, 0, "R8 not yet qualified");
    step(1);         chk(0, 0, "R8 blanking starts");
    neg_tr = 0;
    step(BLANK - 1); chk(0, 0, "R8 blanking still active");
    step(1);         chk(1, 0, "R8 high returns after blanking");

    phase = "R10";
    @(negedge clk); #1 rst_n = 0;
    step(2);         chk(0, 0, "R10 reset clears outputs");
    rst_n = 1;
    step(DEAD - 1);  chk(0, 0, "R10 dead time pending after reset");
    step(1);         chk(1, 0, "R10 first turn-on after reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule